// File: doc/BRIEF.md
# Spare-Column Repair Controller

This controller keeps a programmable AND plane working after cross-point faults appear. The plane's product-term columns are split into output groups of equal size. Each group starts with some columns in use and some held back as spares. A diagnosis unit reports a faulty column by giving its index. The controller then looks for a free spare inside that column's own group and moves the faulty column's programming into the spare. It does this through a cell-level read and write port on the programming memory.

The move happens in three steps:
1. The spare receives the faulty column's programming, one row per clock.
2. The faulty column is programmed with every cell ON. This connects both literals of each variable, so its product term is forced to 0 and drops out of the OR sum.
3. The status entries of both columns are updated.

A spare that is itself reported faulty is retired without any memory traffic, and later searches skip it. When a group has run out of spares, a sticky no-go flag tells the rest of the system that the block can no longer be repaired.

Top module: `spare_column_repair`

## Requirements
- R1: After reset, in every group the lowest `COLS_PER_GROUP-SPARES_PER_GROUP` columns read as in use and the rest as available. `busy`, `noGo` and `memWrEn` are low.
- R2: Each column has a two-bit status at `colState[2c+1:2c]`: 2'b01 available spare, 2'b00 in use, 2'b11 unusable. Code 2'b10 never appears.
- R3: A faulty in-use column is replaced by the lowest-indexed available column of its own group, where group = index / `COLS_PER_GROUP`. Unusable spares are skipped.
- R4: A request is accepted on a clock edge while idle. The next cycle is a decision cycle. During the following `N_ROWS` cycles the spare's row r is written with the faulty column's row r, with r ascending. The faulty column is read through `memRdCol`/`memRdRow`.
- R5: During the next `N_ROWS` cycles, row r of the faulty column is written with 1, again with r ascending.
- R6: One cycle later the faulty column becomes unusable and the spare becomes in use. `busy` stays high for exactly 2·`N_ROWS`+2 cycles per repair.
- R7: A request naming an available spare marks that column unusable after the decision cycle. No memory is written.
- R8: A request naming an unusable column changes no status and writes no memory.
- R9: A request naming an in-use column whose group has no available spare raises `noGo`. Status and memory are left unchanged. `noGo` stays high until reset.
- R10: Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultValid | input | 1 | Fault report strobe |
| faultCol | input | COL_W | Index of the faulty column |
| busy | output | 1 | A request is being handled |
| noGo | output | 1 | Sticky: a group ran out of spares |
| colState | output | 2·N_COLS | Packed per-column status |
| memRdCol | output | COL_W | Read column (faulty column) |
| memRdRow | output | ROW_W | Read row |
| memRdData | input | 1 | Cell value at the read address, combinational |
| memWrEn | output | 1 | Cell write strobe |
| memWrCol | output | COL_W | Write column |
| memWrRow | output | ROW_W | Write row |
| memWrData | output | 1 | Cell value to write (1 = ON) |

## Verification
The bench builds the block with `N_ROWS`=4, `COLS_PER_GROUP`=4 and `SPARES_PER_GROUP`=2, keeping the eight groups. With only two spares per group and four-row copies, every situation the controller handles fits in a few hundred cycles: two spares are used up, a dead spare is skipped, a group runs dry, and further reports arrive against columns that are already retired or were freshly used as spares. The short row count also places the copy-to-neutralise and neutralise-to-commit transitions close together, so an off-by-one in the row counter or the phase change shows up on the write port within a single repair.

// File: rtl/spare_repair_pkg.sv
package spare_repair_pkg;

  typedef enum logic [1:0] {
    COL_IN_USE = 2'b00,
    COL_AVAIL  = 2'b01,
    COL_DEAD   = 2'b11
  } colstat_t;

  typedef struct packed {
    logic latchReq;
    logic markSpareBad;
    logic setNoGo;
    logic startCopy;
    logic copyRow;
    logic neutRow;
    logic commit;
  } repair_strobe_t;

endpackage

// File: rtl/repair_ctrl.sv
module repair_ctrl
  import spare_repair_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           faultValid,
  input  colstat_t       faultyState,
  input  logic           spareFound,
  input  logic           rowLast,
  output repair_strobe_t stb,
  output logic           busy
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_COPY,
    ST_NEUT,
    ST_COMMIT
  } phase_t;

  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    stb       = '0;
    unique case (phase)
      ST_IDLE: begin
        if (faultValid) begin
          stb.latchReq = 1'b1;
          phaseNext    = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        phaseNext = ST_IDLE;
        if (faultyState == COL_AVAIL) begin
          stb.markSpareBad = 1'b1;
        end else if (faultyState == COL_IN_USE) begin
          if (spareFound) begin
            stb.startCopy = 1'b1;
            phaseNext     = ST_COPY;
          end else begin
            stb.setNoGo = 1'b1;
          end
        end
      end
      ST_COPY: begin
        stb.copyRow = 1'b1;
        if (rowLast) phaseNext = ST_NEUT;
      end
      ST_NEUT: begin
        stb.neutRow = 1'b1;
        if (rowLast) phaseNext = ST_COMMIT;
      end
      ST_COMMIT: begin
        stb.commit = 1'b1;
        phaseNext  = ST_IDLE;
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  assign busy = (phase != ST_IDLE);

  // Neutralising starts only once the whole copy has been written (R5)
  p_neut_after_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_COPY && rowLast) |=> (phase == ST_NEUT));

  // Commit happens exactly once, straight after the last neutralise row (R6)
  p_commit_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_COMMIT) |=> (phase == ST_IDLE));

endmodule

// File: rtl/repair_datapath.sv
module repair_datapath
  import spare_repair_pkg::*;
#(
  parameter int N_ROWS           = 32,
  parameter int N_GROUPS         = 8,
  parameter int COLS_PER_GROUP   = 8,
  parameter int SPARES_PER_GROUP = 4,
  localparam int N_COLS          = N_GROUPS * COLS_PER_GROUP,
  localparam int COL_W           = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int ROW_W           = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int ACTIVE_PER_GRP  = COLS_PER_GROUP - SPARES_PER_GROUP
) (
  input  logic                clk,
  input  logic                rstN,
  input  repair_strobe_t      stb,
  input  logic [COL_W-1:0]    faultCol,
  output colstat_t            faultyState,
  output logic                spareFound,
  output logic                rowLast,
  output logic                noGo,
  output logic [2*N_COLS-1:0] colState,
  output logic [COL_W-1:0]    memRdCol,
  output logic [ROW_W-1:0]    memRdRow,
  input  logic                memRdData,
  output logic                memWrEn,
  output logic [COL_W-1:0]    memWrCol,
  output logic [ROW_W-1:0]    memWrRow,
  output logic                memWrData
);

  localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

  logic [COL_W-1:0] reqCol;
  logic [COL_W-1:0] spareCol;
  logic [COL_W-1:0] spareIdx;
  logic [ROW_W-1:0] rowCnt;
  logic [GRP_W-1:0] reqGrp;
  colstat_t         colSt [N_COLS];
  logic [N_COLS-1:0] availVec;

  // Request and chosen-spare registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCol   <= '0;
      spareCol <= '0;
    end else begin
      if (stb.latchReq)  reqCol   <= faultCol;
      if (stb.startCopy) spareCol <= spareIdx;
    end
  end

  // Row sequencer shared by the copy and neutralise passes
  assign rowLast = (rowCnt == ROW_W'(N_ROWS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (stb.startCopy) begin
      rowCnt <= '0;
    end else if (stb.copyRow || stb.neutRow) begin
      rowCnt <= rowLast ? '0 : rowCnt + 1'b1;
    end
  end

  // Sticky go/no-go flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            noGo <= 1'b0;
    else if (stb.setNoGo) noGo <= 1'b1;
  end

  // Group of the requested column
  always_comb begin
    reqGrp = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (int'(reqCol) >= g * COLS_PER_GROUP) reqGrp = GRP_W'(g);
    end
  end

  // Lowest available column of the same group
  always_comb begin
    spareFound = 1'b0;
    spareIdx   = '0;
    for (int c = N_COLS - 1; c >= 0; c--) begin
      if (availVec[c] && ((c / COLS_PER_GROUP) == int'(reqGrp))) begin
        spareFound = 1'b1;
        spareIdx   = COL_W'(c);
      end
    end
  end

  assign faultyState = colSt[reqCol];

  // Per-column status registers
  for (genvar i = 0; i < N_COLS; i++) begin : g_col
    localparam colstat_t RST_STATE =
      ((i % COLS_PER_GROUP) < ACTIVE_PER_GRP) ? COL_IN_USE : COL_AVAIL;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        colSt[i] <= RST_STATE;
      end else if ((stb.markSpareBad || stb.commit) && reqCol == COL_W'(i)) begin
        colSt[i] <= COL_DEAD;
      end else if (stb.commit && spareCol == COL_W'(i)) begin
        colSt[i] <= COL_IN_USE;
      end
    end

    assign availVec[i]        = (colSt[i] == COL_AVAIL);
    assign colState[2*i +: 2] = colSt[i];

    // A retired column never comes back (R8)
    p_dead_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      (colSt[i] == COL_DEAD) |=> (colSt[i] == COL_DEAD));
  end

  // Memory port
  assign memRdCol  = reqCol;
  assign memRdRow  = rowCnt;
  assign memWrEn   = stb.copyRow | stb.neutRow;
  assign memWrCol  = stb.copyRow ? spareCol : reqCol;
  assign memWrRow  = rowCnt;
  assign memWrData = stb.copyRow ? memRdData : 1'b1;

  // Copies stay inside the faulty column's group (R3)
  p_copy_in_group_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyRow |-> ((int'(memWrCol) / COLS_PER_GROUP) == (int'(memRdCol) / COLS_PER_GROUP)));

  // The target spare does not move during a copy (R4)
  p_spare_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.copyRow && $past(stb.copyRow)) |-> $stable(spareCol));

  // A commit consumes exactly one available spare (R6)
  p_one_spare_used_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> ($countones(availVec) == $countones($past(availVec)) - 1));

  // No-go stays asserted until reset (R9)
  p_nogo_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    noGo |=> noGo);

endmodule

// File: rtl/spare_column_repair.sv
module spare_column_repair
  import spare_repair_pkg::*;
#(
  parameter int N_ROWS           = 32,
  parameter int N_GROUPS         = 8,
  parameter int COLS_PER_GROUP   = 8,
  parameter int SPARES_PER_GROUP = 4,
  localparam int N_COLS          = N_GROUPS * COLS_PER_GROUP,
  localparam int COL_W           = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int ROW_W           = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                faultValid,
  input  logic [COL_W-1:0]    faultCol,
  output logic                busy,
  output logic                noGo,
  output logic [2*N_COLS-1:0] colState,
  output logic [COL_W-1:0]    memRdCol,
  output logic [ROW_W-1:0]    memRdRow,
  input  logic                memRdData,
  output logic                memWrEn,
  output logic [COL_W-1:0]    memWrCol,
  output logic [ROW_W-1:0]    memWrRow,
  output logic                memWrData
);

  repair_strobe_t stb;
  colstat_t       faultyState;
  logic           spareFound;
  logic           rowLast;

  repair_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .faultValid  (faultValid),
    .faultyState (faultyState),
    .spareFound  (spareFound),
    .rowLast     (rowLast),
    .stb         (stb),
    .busy        (busy)
  );

  repair_datapath #(
    .N_ROWS           (N_ROWS),
    .N_GROUPS         (N_GROUPS),
    .COLS_PER_GROUP   (COLS_PER_GROUP),
    .SPARES_PER_GROUP (SPARES_PER_GROUP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .faultCol    (faultCol),
    .faultyState (faultyState),
    .spareFound  (spareFound),
    .rowLast     (rowLast),
    .noGo        (noGo),
    .colState    (colState),
    .memRdCol    (memRdCol),
    .memRdRow    (memRdRow),
    .memRdData   (memRdData),
    .memWrEn     (memWrEn),
    .memWrCol    (memWrCol),
    .memWrRow    (memWrRow),
    .memWrData   (memWrData)
  );

  // The memory is only written while a request is in progress (R10)
  p_write_only_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWrEn);

endmodule

// File: tb/spare_column_repair_tb.sv
`timescale 1ns/1ps
module spare_column_repair_tb;

  localparam int NR    = 4;
  localparam int NG    = 8;
  localparam int CPG   = 4;
  localparam int SPG   = 2;
  localparam int NC    = NG * CPG;
  localparam int CW    = $clog2(NC);
  localparam int RW    = $clog2(NR);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          faultValid = 1'b0;
  logic [CW-1:0] faultCol = '0;
  logic          busy, noGo;
  logic [2*NC-1:0] colState;
  logic [CW-1:0] memRdCol, memWrCol;
  logic [RW-1:0] memRdRow, memWrRow;
  logic          memRdData, memWrEn, memWrData;

  always #2.5 clk = ~clk;

  spare_column_repair #(
    .N_ROWS(NR), .N_GROUPS(NG), .COLS_PER_GROUP(CPG), .SPARES_PER_GROUP(SPG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultCol(faultCol),
    .busy(busy), .noGo(noGo), .colState(colState),
    .memRdCol(memRdCol), .memRdRow(memRdRow), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrCol(memWrCol), .memWrRow(memWrRow),
    .memWrData(memWrData)
  );

  // Programming memory seen by the block
  logic mem [NC][NR];
  assign memRdData = mem[memRdCol][memRdRow];
  always @(posedge clk) if (memWrEn) mem[memWrCol][memWrRow] <= memWrData;

  // Behavioural reference: 1 avail, 0 in use, -1 unusable
  int mState [NC];
  bit mMem [NC][NR];
  int mK = -1;
  int mCol, mSpare;
  bit mNoGo;
  int checks = 0, errors = 0;

  task automatic modelReset();
    for (int c = 0; c < NC; c++) mState[c] = ((c % CPG) < (CPG - SPG)) ? 0 : 1;
    mK = -1; mNoGo = 0; mCol = 0; mSpare = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else if (mK < 0) begin
      if (faultValid) begin mCol = int'(faultCol); mK = 0; end
    end else if (mK == 0) begin
      if (mState[mCol] == -1) mK = -1;
      else if (mState[mCol] == 1) begin mState[mCol] = -1; mK = -1; end
      else begin
        mSpare = -1;
        for (int c = NC - 1; c >= 0; c--)
          if (c / CPG == mCol / CPG && mState[c] == 1) mSpare = c;
        if (mSpare < 0) begin mNoGo = 1; mK = -1; end
        else mK = 1;
      end
    end else if (mK == 2*NR + 1) begin
      mState[mCol] = -1; mState[mSpare] = 0; mK = -1;
    end else begin
      if (mK <= NR) mMem[mSpare][mK-1] = mMem[mCol][mK-1];
      else          mMem[mCol][mK-NR-1] = 1'b1;
      mK++;
    end
  end

  function automatic logic [2*NC-1:0] expState();
    logic [2*NC-1:0] v;
    for (int c = 0; c < NC; c++) v[2*c +: 2] = 2'(mState[c]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eWe; int eCol, eRow; bit eData;
      eWe = 0; eCol = 0; eRow = 0; eData = 0;
      if (mK >= 1 && mK <= NR) begin
        eWe = 1; eCol = mSpare; eRow = mK - 1; eData = mMem[mCol][mK-1];
      end else if (mK > NR && mK <= 2*NR) begin
        eWe = 1; eCol = mCol; eRow = mK - NR - 1; eData = 1'b1;
      end
      chk(busy == (mK >= 0), "R6", "busy", busy, mK >= 0);
      chk(noGo == mNoGo, "R9", "noGo", noGo, mNoGo);
      chk(colState == expState(), "R2 R3", "colState", colState, expState());
      chk(memWrEn == eWe, "R4 R5", "memWrEn", memWrEn, eWe);
      if (eWe && memWrEn) begin
        chk(int'(memWrCol) == eCol, (mK <= NR) ? "R4" : "R5", "memWrCol", memWrCol, eCol);
        chk(int'(memWrRow) == eRow, (mK <= NR) ? "R4" : "R5", "memWrRow", memWrRow, eRow);
        chk(memWrData == eData, (mK <= NR) ? "R4" : "R5", "memWrData", memWrData, eData);
        if (mK <= NR)
          chk(int'(memRdCol) == mCol && int'(memRdRow) == eRow, "R4", "read address",
              {memRdCol, memRdRow}, {CW'(mCol), RW'(eRow)});
      end
    end
  end

  task automatic doFault(input int col);
    @(negedge clk); faultValid = 1'b1; faultCol = CW'(col);
    @(negedge clk); faultValid = 1'b0;
    while (mK >= 0) @(negedge clk);
  endtask

  task automatic expectCol(input int col, input logic [1:0] st, input string req);
    chk(colState[2*col +: 2] == st, req, $sformatf("status of column %0d", col),
        colState[2*col +: 2], st);
  endtask

  task automatic memCheck(input string req);
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        chk(mem[c][r] == mMem[c][r], req, $sformatf("cell c%0d r%0d", c, r),
            mem[c][r], mMem[c][r]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected idle");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) begin
        mem[c][r]  = 1'(((c * 5 + r * 3) >> 1) ^ (c >> 2));
        mMem[c][r] = mem[c][r];
      end
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NC; c++)
      expectCol(c, ((c % CPG) < (CPG - SPG)) ? 2'b00 : 2'b01, "R1");
    chk(!busy && !noGo && !memWrEn, "R1", "busy/noGo/memWrEn", {busy, noGo, memWrEn}, 3'b000);
    rstN = 1'b1;

    // R3 R4 R5 R6: column 1 repaired by spare 2
    doFault(1);
    expectCol(1, 2'b11, "R6"); expectCol(2, 2'b00, "R3");
    memCheck("R4 R5");
    // R7: available spare 3 reported faulty
    doFault(3);
    expectCol(3, 2'b11, "R7");
    // R9: group 0 has no spare left
    doFault(0);
    chk(noGo, "R9", "noGo after exhaustion", noGo, 1);
    expectCol(0, 2'b00, "R9");
    // R8: retired column reported again
    doFault(1);
    expectCol(1, 2'b11, "R8"); expectCol(2, 2'b00, "R8");
    // R3: dead spare 22 skipped, 23 chosen for column 20
    doFault(22);
    doFault(20);
    expectCol(23, 2'b00, "R3"); expectCol(20, 2'b11, "R3");
    // R9: former spare now in use, still no spare; flag stays high
    doFault(2);
    chk(noGo, "R9", "noGo sticky", noGo, 1);
    // R10: request during a repair is ignored
    @(negedge clk); faultValid = 1'b1; faultCol = CW'(8);
    @(negedge clk); faultValid = 1'b0;
    repeat (3) @(negedge clk);
    faultValid = 1'b1; faultCol = CW'(9);
    @(negedge clk); faultValid = 1'b0;
    while (mK >= 0) @(negedge clk);
    expectCol(9, 2'b00, "R10"); expectCol(10, 2'b00, "R10");
    // Second group-local repair with a different pattern
    doFault(29);
    expectCol(30, 2'b00, "R3");
    memCheck("R4 R5");
    // R1 R9: reset clears the flag and restores status
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(!noGo, "R9", "noGo cleared by reset", noGo, 0);
    expectCol(1, 2'b00, "R1"); expectCol(2, 2'b01, "R1");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule